// File: doc/BRIEF.md
# Paged Burst Address Generator

This block produces the byte address of every transfer in a burst into a memory array that is organised as pages. A page holds 1024 bytes, addressed by a 10-bit column, and a 13-bit row picks the page. The host starts a burst with a one-cycle start pulse carrying the start address and the burst settings. Each advance strobe then moves the address by one byte. A double-data-rate front end issues one strobe per transferred byte. The block presents the current row and column, marks the first byte of the burst, and flags a start address that was odd.

Three wrap behaviours are supported. A plain wrap cycles forever inside an aligned group of 16, 32, 64 or 1024 bytes. A hybrid wrap makes one pass through the aligned group, jumps to the byte just above it, and counts up through the rest of the page before it wraps over the full page. A linear command ignores both settings and walks the whole page. On a linear read, when crossing is both enabled and supported, the burst continues into the next row instead of wrapping.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held and after it is released, row_o, col_o, first_o and odd_err_o are all 0.
- R2: The clock edge that samples start_i loads row_o from start_addr_i[22:10] and col_o from start_addr_i[9:1] with bit 0 cleared. It also sets first_o to 1.
- R3: odd_err_o takes the value of start_addr_i[0] at each start and holds it until the next start. The column is forced even at start whatever that bit is.
- R4: With linear_i=0, hybrid_i=0 and group code 00/01/10/11 (16/32/64/1024 bytes), each advance moves the column by +1 modulo the group size inside the aligned group that holds the start column. The row does not change.
- R5: With linear_i=0, hybrid_i=1 and code 00/01/10, the column first visits every column of the aligned group once, starting at the start column and wrapping inside the group. It then moves to the group base plus the group size, modulo 1024. After that it counts up by one modulo 1024.
- R6: Hybrid with code 11 gives exactly the plain 1024-byte page wrap.
- R7: With linear_i=1 the group code and hybrid_i have no effect: the column counts up by one modulo 1024 from the start column.
- R8: A linear read (is_write_i=0) started with xrow_en_i=1 and xrow_cap_i=1 steps from column 1023 to column 0 of row+1. Row 8191 rolls over to row 0.
- R9: The row never changes for a write burst, or when xrow_en_i or xrow_cap_i is 0 at start; the column then wraps within the page.
- R10: With neither start nor advance, all outputs hold. The first advance after a start clears first_o.
- R11: A start that arrives during a burst, even in the same cycle as an advance, abandons that burst. The next outputs are the new burst's first byte.
- R12: Advance strobes before the first start after reset have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a burst |
| start_addr_i | input | 23 | Start byte address {row, column} |
| is_write_i | input | 1 | 1 for a write burst, 0 for a read |
| linear_i | input | 1 | Linear command: full-page wrap |
| hybrid_i | input | 1 | Burst type: 1 hybrid, 0 plain wrap |
| blen_i | input | 2 | Group size code: 16/32/64/1024 bytes |
| xrow_en_i | input | 1 | Row crossing enabled for linear reads |
| xrow_cap_i | input | 1 | Array supports row crossing |
| adv_i | input | 1 | Step the address by one byte |
| row_o | output | 13 | Current row |
| col_o | output | 10 | Current column |
| first_o | output | 1 | Current byte is the first of the burst |
| odd_err_o | output | 1 | Last start address was odd |

## Verification
The assertions assume that the burst settings matter only in the cycle of start_i, and that the generator keeps its own copy of them. They also assume that adv_i is meaningful only once a burst is running. The stimulus changes the settings only together with a start pulse. It holds start_i high for a single cycle, except in the deliberate abort case, where a start coincides with an advance in the middle of a burst. Advances come either every cycle or with gaps, so that both holding and stepping occur inside each wrap pattern.

// File: rtl/bag_pkg.sv
package bag_pkg;

    typedef enum logic [1:0] {
        GRP_16   = 2'b00,
        GRP_32   = 2'b01,
        GRP_64   = 2'b10,
        GRP_PAGE = 2'b11
    } grp_code_e;

    typedef enum logic [1:0] {
        MODE_WRAP = 2'b00,
        MODE_HYB  = 2'b01,
        MODE_PAGE = 2'b10
    } walk_mode_e;

endpackage

// File: rtl/bag_cfg_decode.sv
module bag_cfg_decode
    import bag_pkg::*;
#(
    parameter int COL_W    = 10,
    parameter int GRP_LOG0 = 4
) (
    input  logic [1:0]       blen_i,
    input  logic             hybrid_i,
    input  logic             linear_i,
    input  logic             is_write_i,
    input  logic             xrow_en_i,
    input  logic             xrow_cap_i,
    output walk_mode_e       mode_o,
    output logic [COL_W-1:0] mask_o,
    output logic             xrow_o
);
    localparam int LOG_W = $clog2(COL_W + 1);

    grp_code_e        code;
    logic [LOG_W-1:0] grp_log;

    assign code = grp_code_e'(blen_i);

    always_comb begin
        if (code == GRP_PAGE) begin
            grp_log = LOG_W'(COL_W);
        end else begin
            grp_log = LOG_W'(GRP_LOG0) + LOG_W'(blen_i);
        end
    end

    // one mask bit per column bit: set below the group size exponent
    for (genvar gi = 0; gi < COL_W; gi++) begin : g_mask
        assign mask_o[gi] = (LOG_W'(gi) < grp_log);
    end

    always_comb begin
        if (linear_i || code == GRP_PAGE) begin
            mode_o = MODE_PAGE;
        end else if (hybrid_i) begin
            mode_o = MODE_HYB;
        end else begin
            mode_o = MODE_WRAP;
        end
    end

    assign xrow_o = linear_i && !is_write_i && xrow_en_i && xrow_cap_i;

endmodule

// File: rtl/bag_step.sv
module bag_step
    import bag_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int ROW_W = 13
) (
    input  walk_mode_e       mode_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             xrow_i,
    input  logic             phase_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [COL_W-1:0] col_i,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o,
    output logic             phase_o
);
    localparam logic [COL_W-1:0] COL_ONE = COL_W'(1);
    localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);

    logic [COL_W-1:0] col_inc;
    logic [COL_W-1:0] col_wrap;
    logic [COL_W-1:0] grp_above;

    assign col_inc   = col_i + COL_ONE;
    assign col_wrap  = (col_i & ~mask_i) | (col_inc & mask_i);
    assign grp_above = (start_col_i & ~mask_i) + mask_i + COL_ONE;

    always_comb begin
        row_o   = row_i;
        col_o   = col_wrap;
        phase_o = phase_i;
        unique case (mode_i)
            MODE_PAGE: begin
                col_o = col_inc;
                if (xrow_i && (&col_i)) begin
                    row_o = row_i + ROW_ONE;
                end
            end
            MODE_HYB: begin
                if (phase_i) begin
                    col_o = col_inc;
                end else if (col_wrap == start_col_i) begin
                    col_o   = grp_above;
                    phase_o = 1'b1;
                end else begin
                    col_o = col_wrap;
                end
            end
            default: begin
                col_o = col_wrap;
            end
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int COL_W    = 10,
    parameter int ROW_W    = 13,
    parameter int GRP_LOG0 = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [ROW_W+COL_W-1:0] start_addr_i,
    input  logic                   is_write_i,
    input  logic                   linear_i,
    input  logic                   hybrid_i,
    input  logic [1:0]             blen_i,
    input  logic                   xrow_en_i,
    input  logic                   xrow_cap_i,
    input  logic                   adv_i,
    output logic [ROW_W-1:0]       row_o,
    output logic [COL_W-1:0]       col_o,
    output logic                   first_o,
    output logic                   odd_err_o
);
    localparam int ADDR_W = ROW_W + COL_W;

    typedef struct packed {
        logic             active;
        logic             first;
        logic             err;
        logic             phase;
        walk_mode_e       mode;
        logic             xrow;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] start_col;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } gen_state_t;

    gen_state_t st_d, st_q;

    walk_mode_e       dec_mode;
    logic [COL_W-1:0] dec_mask;
    logic             dec_xrow;
    logic [ROW_W-1:0] stp_row;
    logic [COL_W-1:0] stp_col;
    logic             stp_phase;
    logic [COL_W-1:0] load_col;

    bag_cfg_decode #(
        .COL_W    (COL_W),
        .GRP_LOG0 (GRP_LOG0)
    ) u_dec (
        .blen_i     (blen_i),
        .hybrid_i   (hybrid_i),
        .linear_i   (linear_i),
        .is_write_i (is_write_i),
        .xrow_en_i  (xrow_en_i),
        .xrow_cap_i (xrow_cap_i),
        .mode_o     (dec_mode),
        .mask_o     (dec_mask),
        .xrow_o     (dec_xrow)
    );

    bag_step #(
        .COL_W (COL_W),
        .ROW_W (ROW_W)
    ) u_step (
        .mode_i      (st_q.mode),
        .mask_i      (st_q.mask),
        .xrow_i      (st_q.xrow),
        .phase_i     (st_q.phase),
        .start_col_i (st_q.start_col),
        .row_i       (st_q.row),
        .col_i       (st_q.col),
        .row_o       (stp_row),
        .col_o       (stp_col),
        .phase_o     (stp_phase)
    );

    assign load_col = {start_addr_i[COL_W-1:1], 1'b0};

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active    = 1'b1;
            st_d.first     = 1'b1;
            st_d.err       = start_addr_i[0];
            st_d.phase     = 1'b0;
            st_d.mode      = dec_mode;
            st_d.xrow      = dec_xrow;
            st_d.mask      = dec_mask;
            st_d.start_col = load_col;
            st_d.row       = start_addr_i[ADDR_W-1:COL_W];
            st_d.col       = load_col;
        end else if (adv_i && st_q.active) begin
            st_d.first = 1'b0;
            st_d.phase = stp_phase;
            st_d.row   = stp_row;
            st_d.col   = stp_col;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{default: '0, mode: MODE_WRAP};
        end else begin
            st_q <= st_d;
        end
    end

    assign row_o     = st_q.row;
    assign col_o     = st_q.col;
    assign first_o   = st_q.first;
    assign odd_err_o = st_q.err;

    // ---------------- assertions ----------------
    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (first_o && row_o == $past(start_addr_i[ADDR_W-1:COL_W])
                     && col_o[0] == 1'b0));

    p_odd_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (odd_err_o == $past(start_addr_i[0])));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !adv_i) |=> ($stable(col_o) && $stable(row_o)
                                 && $stable(first_o) && $stable(odd_err_o)));

    p_first_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && adv_i) |=> !first_o);

    p_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && adv_i && st_q.active) |=> (col_o != $past(col_o)));

    p_row_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !st_q.xrow) |=> $stable(row_o));

    p_cross_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && adv_i && st_q.xrow && (&col_o)) |=>
            (col_o == '0 && row_o == $past(row_o) + ROW_W'(1)));

    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !start_i) |=> (row_o == '0 && col_o == '0 && !first_o));

endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [22:0] start_addr_i = '0;
    logic        is_write_i = 1'b0;
    logic        linear_i = 1'b0;
    logic        hybrid_i = 1'b0;
    logic [1:0]  blen_i = 2'b00;
    logic        xrow_en_i = 1'b0;
    logic        xrow_cap_i = 1'b0;
    logic        adv_i = 1'b0;
    logic [12:0] row_o;
    logic [9:0]  col_o;
    logic        first_o;
    logic        odd_err_o;

    int tests = 0;
    int fails = 0;

    // reference burst description
    int r0, c0, bl;
    bit lin, hyb, xr, eerr;

    always #4 clk = ~clk;

    burst_addr_gen u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_addr_i (start_addr_i),
        .is_write_i   (is_write_i),
        .linear_i     (linear_i),
        .hybrid_i     (hybrid_i),
        .blen_i       (blen_i),
        .xrow_en_i    (xrow_en_i),
        .xrow_cap_i   (xrow_cap_i),
        .adv_i        (adv_i),
        .row_o        (row_o),
        .col_o        (col_o),
        .first_o      (first_o),
        .odd_err_o    (odd_err_o)
    );

    // address of byte k of the current burst, computed by index
    function automatic void ref_addr(input int k, output int er, output int ec);
        int g, base, idx;
        g = (bl == 3) ? 1024 : (16 << bl);
        er = r0;
        if (lin) begin
            idx = c0 + k;
            ec = idx % 1024;
            if (xr) er = (r0 + idx / 1024) % 8192;
        end else begin
            base = (c0 / g) * g;
            if (hyb && bl != 3 && k >= g) ec = (base + g + (k - g)) % 1024;
            else ec = base + ((c0 - base + k) % g);
        end
    endfunction

    task automatic check_raw(string tag, int er, int ec, bit ef, bit ee);
        tests++;
        if (int'(row_o) != er || int'(col_o) != ec || first_o != ef || odd_err_o != ee) begin
            fails++;
            $display("FAIL %s: got row=%0d col=%0d first=%0b err=%0b, expected row=%0d col=%0d first=%0b err=%0b",
                     tag, row_o, col_o, first_o, odd_err_o, er, ec, ef, ee);
        end
    endtask

    task automatic check_k(string tag, int k);
        int er, ec;
        ref_addr(k, er, ec);
        check_raw(tag, er, ec, (k == 0), eerr);
    endtask

    task automatic burst(string tag, int row, int col, bit w, bit l, bit h, int b,
                         bit xe, bit xc, int n, bit gaps, bit adv_on_start);
        int k, cyc;
        @(negedge clk);
        start_i      = 1'b1;
        start_addr_i = {row[12:0], col[9:0]};
        is_write_i   = w;
        linear_i     = l;
        hybrid_i     = h;
        blen_i       = b[1:0];
        xrow_en_i    = xe;
        xrow_cap_i   = xc;
        adv_i        = adv_on_start;
        r0 = row; c0 = col & ~1; bl = b; lin = l; hyb = h;
        xr = l && !w && xe && xc;
        eerr = col[0];
        @(negedge clk);
        start_i = 1'b0;
        k = 0;
        cyc = 0;
        check_k(tag, k);
        while (k < n) begin
            adv_i = gaps ? (cyc % 3 != 1) : 1'b1;
            cyc++;
            @(negedge clk);
            if (adv_i) k++;
            check_k(tag, k);
        end
        adv_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        check_raw("R1 in reset", 0, 0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_raw("R1 after reset", 0, 0, 1'b0, 1'b0);
        // R12: advance with no burst started
        adv_i = 1'b1;
        repeat (4) @(negedge clk);
        check_raw("R12 advance before start", 0, 0, 1'b0, 1'b0);
        adv_i = 1'b0;

        // R4: plain wraps of each size
        burst("R4 wrap16 from 4", 3, 4, 1'b0, 1'b0, 1'b0, 0, 1'b1, 1'b1, 40, 1'b0, 1'b0);
        burst("R4 wrap32 gaps", 100, 38, 1'b1, 1'b0, 1'b0, 1, 1'b0, 1'b0, 70, 1'b1, 1'b0);
        burst("R4 wrap64 top", 8191, 1018, 1'b0, 1'b0, 1'b0, 2, 1'b1, 1'b1, 140, 1'b0, 1'b0);
        burst("R4 wrap1024", 9, 1000, 1'b0, 1'b0, 1'b0, 3, 1'b1, 1'b1, 60, 1'b0, 1'b0);
        // R5: hybrid
        burst("R5 hybrid16 from 2", 12, 2, 1'b0, 1'b0, 1'b1, 0, 1'b1, 1'b1, 1040, 1'b0, 1'b0);
        burst("R5 hybrid32 gaps", 44, 70, 1'b1, 1'b0, 1'b1, 1, 1'b0, 1'b0, 120, 1'b1, 1'b0);
        burst("R5 hybrid64 last group", 5, 966, 1'b0, 1'b0, 1'b1, 2, 1'b0, 1'b0, 90, 1'b0, 1'b0);
        // R6: hybrid with page code
        burst("R6 hybrid page", 77, 2, 1'b0, 1'b0, 1'b1, 3, 1'b0, 1'b0, 1030, 1'b0, 1'b0);
        // R7 and R9: linear write ignores type, length and crossing enable
        burst("R7 R9 linear write", 20, 1008, 1'b1, 1'b1, 1'b1, 0, 1'b1, 1'b1, 40, 1'b0, 1'b0);
        burst("R7 linear read no cross", 21, 6, 1'b0, 1'b1, 1'b0, 1, 1'b0, 1'b1, 50, 1'b1, 1'b0);
        // R8: crossing into next row and rollover
        burst("R8 cross row 7", 7, 1012, 1'b0, 1'b1, 1'b0, 2, 1'b1, 1'b1, 30, 1'b0, 1'b0);
        burst("R8 rollover row 8191", 8191, 1016, 1'b0, 1'b1, 1'b1, 1, 1'b1, 1'b1, 20, 1'b1, 1'b0);
        // R9: crossing not supported keeps row
        burst("R9 cap off", 30, 1016, 1'b0, 1'b1, 1'b0, 0, 1'b1, 1'b0, 20, 1'b0, 1'b0);
        // R3: odd start forced even and flagged, then cleared by even start
        burst("R3 odd start", 40, 9, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 20, 1'b0, 1'b0);
        burst("R3 even clears flag", 41, 10, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 4, 1'b0, 1'b0);
        // R11: abort a running burst with start and advance together
        burst("R11 first burst", 50, 20, 1'b0, 1'b0, 1'b1, 1, 1'b0, 1'b0, 10, 1'b0, 1'b0);
        adv_i = 1'b1;
        burst("R11 abort with advance", 60, 500, 1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b0, 12, 1'b0, 1'b1);
        // R10: hold with no advance
        repeat (3) @(negedge clk);
        check_k("R10 hold idle", 12);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule